// File: doc/BRIEF.md
# Two-Thread Pipeline Slot Arbiter

This block hands out one pipeline-stage slot per clock (a fetch, decode or rename slot, for example) to one of two hardware thread contexts. It also tracks how many entries each thread holds in a shared reorder-style buffer, and it caps that occupancy per thread. The grant is a combinational one-hot vector computed from this cycle's requests and the registered state. The caller uses it to steer the stage. Allocate and retire pulses from the pipeline keep the per-thread counts up to date.

While both threads are awake the buffer is split evenly, and threads that can both proceed take turns. A thread that is stalled or at its cap gives its slot to the other thread. A thread can go to sleep once it holds no entries. The core then runs in single-thread mode: the remaining thread may fill the whole buffer and win every slot. When the sleeping thread wakes, it has to wait until the running thread has drained to half the buffer or less. Only then does the split return.

Top module: `smt_slot_arbiter`

## Requirements
- R1: When both threads are eligible in consecutive cycles, the grant alternates between them. A thread is eligible when it is awake, requesting, not stalled and below its cap.
- R2: Grant bit i is set only for an eligible thread, and never for more than one thread. A lone eligible thread wins in every cycle, and with no eligible thread the grant is 0.
- R3: The turn pointer changes only in contested cycles. After reset thread 0 wins the first contested cycle. After each contested grant the other thread wins the next contested cycle, regardless of how many uncontested cycles come between.
- R4: With both threads awake, each thread's cap is DEPTH/2 entries. full_o[i] is high when thread i's count is at or above its cap, and a full thread receives no grant.
- R5: An allocate pulse for a thread at its cap is ignored, and a retire pulse for a thread at zero is ignored. An allocate and a retire in the same cycle leave the count unchanged.
- R6: A sleep request takes effect only in a cycle where the thread's next count is zero. An asleep thread gets no grant, has a cap of 0 and reports full_o high.
- R7: With exactly one thread awake, that thread's cap is the full DEPTH.
- R8: A sleeping thread whose sleep request drops wakes only in a cycle where the other thread's next count is at most DEPTH/2. Until then it stays asleep.
- R9: After reset both counts are zero, both threads are awake and the grant is 0 with no requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 2 | Per-thread slot request |
| stall_i | input | 2 | Per-thread stall (miss, recovery) |
| sleep_i | input | 2 | Per-thread sleep request, level |
| alloc_i | input | 2 | Per-thread buffer allocate pulse |
| retire_i | input | 2 | Per-thread buffer retire pulse |
| grant_o | output | 2 | One-hot slot grant |
| full_o | output | 2 | Per-thread buffer at cap |

## Verification
The grant is driven with a sequence of request and stall patterns. Back-to-back contested cycles show true alternation as distinct from fixed priority. One-sided stalls show that the slot is handed over. Uncontested cycles placed between contested ones show that the turn pointer holds instead of advancing on every cycle. Buffer sequences fill the buffer to the cap, push past it, and retire below zero; the full flag then exposes any lost or extra count. Sleep and wake sequences are timed around the zero count and the half-depth mark. They show that a transition happens no earlier than allowed, and that the cap changes between half and full depth.

// File: rtl/smt_arb_pkg.sv
package smt_arb_pkg;
    localparam int NTHR = 2;

    typedef struct packed {
        logic [NTHR-1:0] awake;
        logic            turn;
    } arb_state_t;
endpackage

// File: rtl/smt_occ_counter.sv
module smt_occ_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic             retire_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] occ_q_o,
    output logic [CNT_W-1:0] occ_d_o,
    output logic             full_o
);
    logic [CNT_W-1:0] occ_d, occ_q;
    logic             take_ret, take_alloc;

    always_comb begin
        take_ret   = retire_i && (occ_q != '0);
        take_alloc = alloc_i && ((occ_q < limit_i) || take_ret);
        occ_d      = occ_q;
        if (take_alloc && !take_ret) begin
            occ_d = occ_q + 1'b1;
        end else if (take_ret && !take_alloc) begin
            occ_d = occ_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_d;
    end

    assign occ_q_o = occ_q;
    assign occ_d_o = occ_d;
    assign full_o  = (occ_q >= limit_i);
endmodule

// File: rtl/smt_grant_pick.sv
module smt_grant_pick (
    input  logic [1:0] elig_i,
    input  logic       turn_i,
    output logic [1:0] grant_o,
    output logic       contested_o
);
    always_comb begin
        contested_o = &elig_i;
        grant_o     = 2'b00;
        if (contested_o) begin
            grant_o = turn_i ? 2'b10 : 2'b01;
        end else begin
            grant_o = elig_i;
        end
    end
endmodule

// File: rtl/smt_slot_arbiter.sv
module smt_slot_arbiter #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req_i,
    input  logic [1:0] stall_i,
    input  logic [1:0] sleep_i,
    input  logic [1:0] alloc_i,
    input  logic [1:0] retire_i,
    output logic [1:0] grant_o,
    output logic [1:0] full_o
);
    import smt_arb_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] HALF_CAP = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] FULL_CAP = CNT_W'(DEPTH);

    if ((DEPTH % 2) != 0 || DEPTH < 2) begin : g_bad_depth
        $error("smt_slot_arbiter: DEPTH must be even and at least 2");
    end

    arb_state_t              st_d, st_q;
    logic [1:0][CNT_W-1:0]   limit;
    logic [1:0][CNT_W-1:0]   occ_q, occ_d;
    logic [1:0]              elig;
    logic                    contested;

    always_comb begin
        for (int t = 0; t < NTHR; t++) begin
            if (!st_q.awake[t])   limit[t] = '0;
            else if (&st_q.awake) limit[t] = HALF_CAP;
            else                  limit[t] = FULL_CAP;
        end
    end

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        smt_occ_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc_i  (alloc_i[t]),
            .retire_i (retire_i[t]),
            .limit_i  (limit[t]),
            .occ_q_o  (occ_q[t]),
            .occ_d_o  (occ_d[t]),
            .full_o   (full_o[t])
        );
        assign elig[t] = st_q.awake[t] && req_i[t] && !stall_i[t] && !full_o[t];
    end

    smt_grant_pick u_pick (
        .elig_i      (elig),
        .turn_i      (st_q.turn),
        .grant_o     (grant_o),
        .contested_o (contested)
    );

    always_comb begin
        st_d = st_q;
        if (contested) st_d.turn = ~st_q.turn;
        for (int t = 0; t < NTHR; t++) begin
            if (st_q.awake[t]) begin
                st_d.awake[t] = !(sleep_i[t] && (occ_d[t] == '0));
            end else begin
                st_d.awake[t] = !sleep_i[t] && (occ_d[1-t] <= HALF_CAP);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.awake <= '1;
            st_q.turn  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [1:0] awake_w;
    assign awake_w = st_q.awake;
endmodule

// File: rtl/smt_slot_arbiter_chk.sv
module smt_slot_arbiter_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       req_i,
    input logic [1:0]       stall_i,
    input logic [1:0]       grant_o,
    input logic [1:0]       full_o,
    input logic [1:0]       awake,
    input logic [CNT_W-1:0] occ0,
    input logic [CNT_W-1:0] occ1
);
    logic [1:0] ok;
    assign ok = awake & req_i & ~stall_i & ~full_o;

    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    assert_grant_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~ok) == 2'b00);

    assert_alternate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (&ok) && $past(&ok)) |-> (grant_o != $past(grant_o)));

    assert_split_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (&awake) |-> ((occ0 <= CNT_W'(DEPTH/2)) && (occ1 <= CNT_W'(DEPTH/2))));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (occ0 <= CNT_W'(DEPTH)) && (occ1 <= CNT_W'(DEPTH)));

    assert_sleep_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((!awake[0] -> occ0 == '0) && (!awake[1] -> occ1 == '0)));

    assert_wake_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(awake[0]) |-> occ1 <= CNT_W'(DEPTH/2)));

    assert_wake_room1_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(awake[1]) |-> occ0 <= CNT_W'(DEPTH/2)));
endmodule

bind smt_slot_arbiter smt_slot_arbiter_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .stall_i (stall_i),
    .grant_o (grant_o),
    .full_o  (full_o),
    .awake   (awake_w),
    .occ0    (occ_q[0]),
    .occ1    (occ_q[1])
);

// File: tb/smt_slot_arbiter_tb.sv
module smt_slot_arbiter_tb;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int NVEC   = 13;
    // each entry: {req[1:0], stall[1:0], expected grant[1:0]}
    localparam logic [5:0] VEC [NVEC] = '{
        6'b11_00_01, 6'b11_00_10, 6'b11_00_01, 6'b11_01_10, 6'b11_01_10,
        6'b11_00_10, 6'b01_00_01, 6'b01_00_01, 6'b11_00_01, 6'b00_00_00,
        6'b11_11_00, 6'b11_10_01, 6'b11_00_10
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] req = '0, stall = '0, slp = '0, alloc = '0, retire = '0;
    logic [1:0] grant, full;
    int         n_run = 0, n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    smt_slot_arbiter #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .stall_i(stall), .sleep_i(slp),
        .alloc_i(alloc), .retire_i(retire), .grant_o(grant), .full_o(full)
    );

    task automatic drive(input logic [1:0] r, input logic [1:0] s, input logic [1:0] sl,
                         input logic [1:0] a, input logic [1:0] rt);
        @(negedge clk);
        req = r; stall = s; slp = sl; alloc = a; retire = rt;
        #1;
    endtask

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic repeat_drive(input int n, input logic [1:0] sl,
                                input logic [1:0] a, input logic [1:0] rt);
        for (int i = 0; i < n; i++) drive(2'b00, 2'b00, sl, a, rt);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R9 reset state
        drive(2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
        chk("R9 grant idle", grant, 2'b00);
        chk("R9 full after reset", full, 2'b00);

        // R1 R2 R3 arbitration table
        for (int v = 0; v < NVEC; v++) begin
            drive(VEC[v][5:4], VEC[v][3:2], 2'b00, 2'b00, 2'b00);
            chk($sformatf("R1/R2/R3 vector %0d", v), grant, VEC[v][1:0]);
        end

        // R4 split cap, R5 overflow ignored
        repeat_drive(8, 2'b00, 2'b01, 2'b00);
        drive(2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
        chk("R4 full at half", full, 2'b01);
        drive(2'b01, 2'b00, 2'b00, 2'b01, 2'b00);
        chk("R4 full blocks grant", grant, 2'b00);
        drive(2'b00, 2'b00, 2'b00, 2'b00, 2'b01);
        drive(2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
        chk("R5 alloc at cap ignored", full, 2'b00);
        drive(2'b00, 2'b00, 2'b00, 2'b01, 2'b01);
        drive(2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
        chk("R5 alloc+retire net zero", full, 2'b00);
        drive(2'b00, 2'b00, 2'b00, 2'b01, 2'b00);
        drive(2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
        chk("R5 count back at cap", full, 2'b01);
        // R5 retire at zero ignored
        repeat_drive(10, 2'b00, 2'b00, 2'b01);
        repeat_drive(7, 2'b00, 2'b01, 2'b00);
        drive(2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
        chk("R5 no underflow (7)", full, 2'b00);
        drive(2'b00, 2'b00, 2'b00, 2'b01, 2'b00);
        drive(2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
        chk("R5 no underflow (8)", full, 2'b01);
        repeat_drive(8, 2'b00, 2'b00, 2'b01);

        // R6 sleep denied while holding an entry
        drive(2'b00, 2'b00, 2'b00, 2'b01, 2'b00);
        drive(2'b00, 2'b00, 2'b01, 2'b00, 2'b00);
        drive(2'b11, 2'b00, 2'b01, 2'b00, 2'b00);
        chk("R6 sleep held off", full, 2'b00);
        drive(2'b00, 2'b00, 2'b01, 2'b00, 2'b01);
        drive(2'b11, 2'b00, 2'b01, 2'b00, 2'b00);
        chk("R6 asleep full flag", full, 2'b01);
        chk("R6 asleep no grant", grant, 2'b10);
        drive(2'b11, 2'b00, 2'b01, 2'b00, 2'b00);
        chk("R7 single thread every cycle", grant, 2'b10);

        // R7 full cap in single mode
        repeat_drive(15, 2'b01, 2'b10, 2'b00);
        drive(2'b00, 2'b00, 2'b01, 2'b00, 2'b00);
        chk("R7 past half not full", full, 2'b01);
        drive(2'b00, 2'b00, 2'b01, 2'b10, 2'b00);
        drive(2'b00, 2'b00, 2'b01, 2'b00, 2'b00);
        chk("R7 full at depth", full, 2'b11);

        // R8 wake deferred until other thread drains to half
        repeat_drive(7, 2'b00, 2'b00, 2'b10);
        drive(2'b11, 2'b00, 2'b00, 2'b00, 2'b00);
        chk("R8 wake held off", full, 2'b01);
        chk("R8 held thread no grant", grant, 2'b10);
        drive(2'b00, 2'b00, 2'b00, 2'b00, 2'b10);
        drive(2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
        chk("R8 woke, split restored", full, 2'b10);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule